// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small record of why the system last came out of reset or out of its low-power stop state. Each possible cause reaches the block as a one-cycle event strobe. There are seven causes: power-on, the external reset pin, a watchdog timeout while running, a debugger-requested reset, a debug-pin wake from stop, a GPIO-transition wake from stop, and a watchdog wake from stop. The block turns the selected event into four flags: power-on, stop recovery, watchdog and external pin. When the stop flag and the watchdog flag are both set, the wake came from the watchdog. When only the stop flag is set, it came from some other source.

Software reads the flags over a simple bus read port. The returned byte also holds three reserved bits and a stop-mode configuration bit. Every read returns the flags as they stood before the read and then clears them. The configuration bit can be written. It comes out on a port so the clock logic can turn off the watchdog during stop.

Top module: `reset_cause_reg`

## Requirements
- R1: After hardware reset (rst_n low), the flags are power-on=1, stop=0, watchdog=0, external=0, and the configuration bit is 0. The first read therefore returns 0x80.
- R2: A power-on event sets the flags to 1,0,0,0 (power-on, stop, watchdog, external) and clears the configuration bit.
- R3: An external-pin event sets the flags to 0,0,0,1.
- R4: A watchdog timeout while running sets the flags to 0,0,1,0.
- R5: A debugger-requested reset sets the flags to 1,0,0,0, and so does a debug-pin wake from stop. Neither changes the configuration bit.
- R6: A GPIO wake from stop sets the flags to 0,1,0,0. A watchdog wake from stop sets them to 0,1,1,0.
- R7: A read (rdEn high at a clock edge) loads rdData at that edge with the flags as they were before the edge. The read also clears all four flags. The layout of rdData is: bit 7 power-on, bit 6 stop, bit 5 watchdog, bit 4 external, bit 0 configuration.
- R8: When an event and a read happen in the same cycle, the read returns the old flags and the flags then hold the event's values.
- R9: Bits 3:1 of rdData always read 0, even after writes of all ones.
- R10: A write (wrEn) loads the configuration bit from wrData[0], and the bit drives stopWdtOff. A power-on event in the same cycle wins and clears the bit.
- R11: When several events arrive together, exactly one is applied. The order from highest to lowest is: power-on, debugger reset, debug-pin wake, external pin, watchdog while running, watchdog wake, GPIO wake.
- R12: rdData holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| evtPowerOn | input | 1 | Power-on event strobe |
| evtExtPin | input | 1 | External reset pin event strobe |
| evtWdtRun | input | 1 | Watchdog timeout while running |
| evtDbgReset | input | 1 | Debugger-requested reset |
| evtDbgWake | input | 1 | Debug-pin wake from stop |
| evtGpioWake | input | 1 | GPIO-transition wake from stop |
| evtWdtWake | input | 1 | Watchdog wake from stop |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data; bit 0 is the configuration bit |
| rdData | output | 8 | Registered read data |
| stopWdtOff | output | 1 | Configuration bit: 1 turns off the watchdog during stop |

## Verification
The bench targets a read that collides with an event. A design that let the clear win would lose the new cause, and one that sampled after the update would return the new flags instead of the old ones. It also targets events that arrive together: a design with the wrong order would report, for example, an external reset over a power-on. It targets a write to the configuration bit in the same cycle as power-on, where a wrong design keeps the written value. Finally, it checks that the two stop wakes differ only in the watchdog flag, which a design that mixed up their patterns would get wrong.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_FLAGS = 4;
  localparam int NUM_EVT   = 7;
  localparam int POS_SM    = 0;
  localparam int POS_FLAGS = DATA_W - NUM_FLAGS;
  localparam int RSVD_W    = POS_FLAGS - POS_SM - 1;

  // Event index doubles as priority: lower index wins.
  typedef enum logic [2:0] {
    EV_POWER    = 3'd0,
    EV_DBGRST   = 3'd1,
    EV_DBGWAKE  = 3'd2,
    EV_EXTPIN   = 3'd3,
    EV_WDTRUN   = 3'd4,
    EV_WDTWAKE  = 3'd5,
    EV_GPIOWAKE = 3'd6
  } evt_e;

  typedef struct packed {
    logic                 loadFlags;
    logic [NUM_FLAGS-1:0] flagVal;
    logic                 clearFlags;
    logic                 captureRead;
    logic                 writeSm;
    logic                 resetSm;
  } ctl_s;

  // Flag order {powerOn, stop, watchdog, external}.
  function automatic logic [NUM_FLAGS-1:0] flagPattern(input int idx);
    case (idx)
      EV_POWER, EV_DBGRST, EV_DBGWAKE: flagPattern = 4'b1000;
      EV_EXTPIN:                       flagPattern = 4'b0001;
      EV_WDTRUN:                       flagPattern = 4'b0010;
      EV_WDTWAKE:                      flagPattern = 4'b0110;
      EV_GPIOWAKE:                     flagPattern = 4'b0100;
      default:                         flagPattern = '0;
    endcase
  endfunction
endpackage

// File: rtl/rcause_ctrl.sv
module rcause_ctrl
  import rcause_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic               rdEn,
  input  logic               wrEn,
  output ctl_s               ctl
);
  logic [NUM_EVT-1:0]   grant;
  logic [NUM_FLAGS-1:0] flagMux;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evtVec[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    flagMux = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (grant[i]) flagMux = flagMux | flagPattern(i);
    end
  end

  always_comb begin
    ctl.loadFlags   = |grant;
    ctl.flagVal     = flagMux;
    ctl.clearFlags  = rdEn;
    ctl.captureRead = rdEn;
    ctl.writeSm     = wrEn;
    ctl.resetSm     = evtVec[EV_POWER];
  end

  assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~evtVec) == '0));

  assert_grant_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evtVec != '0) |-> (grant != '0));
endmodule

// File: rtl/rcause_dp.sv
module rcause_dp
  import rcause_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_s              ctl,
  input  logic              wrBit,
  output logic [DATA_W-1:0] rdData,
  output logic              smOut
);
  logic [NUM_FLAGS-1:0] flagsQ;
  logic                 smQ;
  logic [DATA_W-1:0]    rdQ;
  logic [DATA_W-1:0]    rdWord;

  always_comb begin
    rdWord                              = '0;
    rdWord[DATA_W-1:POS_FLAGS]          = flagsQ;
    rdWord[POS_SM]                      = smQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= 4'b1000;
      smQ    <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (ctl.loadFlags)       flagsQ <= ctl.flagVal;
      else if (ctl.clearFlags) flagsQ <= '0;
      if (ctl.resetSm)         smQ <= 1'b0;
      else if (ctl.writeSm)    smQ <= wrBit;
      if (ctl.captureRead)     rdQ <= rdWord;
    end
  end

  assign rdData = rdQ;
  assign smOut  = smQ;

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clearFlags && !ctl.loadFlags) |=> (flagsQ == '0));

  assert_read_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.captureRead |=> (rdData[DATA_W-1:POS_FLAGS] == $past(flagsQ)));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadFlags |=> (flagsQ == $past(ctl.flagVal)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.captureRead |=> $stable(rdData));

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[POS_FLAGS-1:POS_SM+1] == '0);
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcause_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtPowerOn,
  input  logic              evtExtPin,
  input  logic              evtWdtRun,
  input  logic              evtDbgReset,
  input  logic              evtDbgWake,
  input  logic              evtGpioWake,
  input  logic              evtWdtWake,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              stopWdtOff
);
  logic [NUM_EVT-1:0] evtVec;
  ctl_s               ctl;

  always_comb begin
    evtVec              = '0;
    evtVec[EV_POWER]    = evtPowerOn;
    evtVec[EV_DBGRST]   = evtDbgReset;
    evtVec[EV_DBGWAKE]  = evtDbgWake;
    evtVec[EV_EXTPIN]   = evtExtPin;
    evtVec[EV_WDTRUN]   = evtWdtRun;
    evtVec[EV_WDTWAKE]  = evtWdtWake;
    evtVec[EV_GPIOWAKE] = evtGpioWake;
  end

  rcause_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .evtVec (evtVec),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .ctl    (ctl)
  );

  rcause_dp u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .wrBit  (wrData[POS_SM]),
    .rdData (rdData),
    .smOut  (stopWdtOff)
  );

  assert_poweron_sm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evtPowerOn |=> !stopWdtOff);

  assert_write_sm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !evtPowerOn) |=> (stopWdtOff == $past(wrData[POS_SM])));

  assert_sm_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !evtPowerOn) |=> $stable(stopWdtOff));
endmodule

// File: tb/reset_cause_reg_bench.sv
`timescale 1ns/1ps
module reset_cause_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evtPowerOn = 0, evtExtPin = 0, evtWdtRun = 0, evtDbgReset = 0;
  logic evtDbgWake = 0, evtGpioWake = 0, evtWdtWake = 0;
  logic rdEn = 0, wrEn = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic stopWdtOff;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] mFlags;
  logic       mSm;
  logic [7:0] mRd;

  // Event bit order in the bench: 0 power,1 dbgRst,2 dbgWake,3 ext,4 wdtRun,5 wdtWake,6 gpio
  localparam logic [6:0] E_POW = 7'h01, E_DRS = 7'h02, E_DWK = 7'h04, E_EXT = 7'h08,
                         E_WRN = 7'h10, E_WWK = 7'h20, E_GPI = 7'h40;

  always #2 clk = ~clk;

  reset_cause_reg u_reset_cause_reg (
    .clk(clk), .rst_n(rst_n),
    .evtPowerOn(evtPowerOn), .evtExtPin(evtExtPin), .evtWdtRun(evtWdtRun),
    .evtDbgReset(evtDbgReset), .evtDbgWake(evtDbgWake), .evtGpioWake(evtGpioWake),
    .evtWdtWake(evtWdtWake), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .stopWdtOff(stopWdtOff)
  );

  function automatic logic [3:0] expFlags(input logic [6:0] ev, input logic [3:0] cur, input logic rd);
    if      (ev[0]) return 4'b1000;
    else if (ev[1]) return 4'b1000;
    else if (ev[2]) return 4'b1000;
    else if (ev[3]) return 4'b0001;
    else if (ev[4]) return 4'b0010;
    else if (ev[5]) return 4'b0110;
    else if (ev[6]) return 4'b0100;
    else if (rd)    return 4'b0000;
    return cur;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] ev, input logic rd, input logic wr,
                      input logic [7:0] wd, input string tag);
    @(negedge clk);
    {evtGpioWake, evtWdtWake, evtWdtRun, evtExtPin, evtDbgWake, evtDbgReset, evtPowerOn} = ev;
    rdEn = rd; wrEn = wr; wrData = wd;
    @(posedge clk);
    if (rd) mRd = {mFlags, 3'b000, mSm};
    mFlags = expFlags(ev, mFlags, rd);
    if (ev[0]) mSm = 1'b0;
    else if (wr) mSm = wd[0];
    #1;
    check8(tag, rdData, mRd);
    check8(tag, {7'b0, stopWdtOff}, {7'b0, mSm});
    @(negedge clk);
    {evtGpioWake, evtWdtWake, evtWdtRun, evtExtPin, evtDbgWake, evtDbgReset, evtPowerOn} = '0;
    rdEn = 0; wrEn = 0; wrData = '0;
  endtask

  task automatic evRead(input logic [6:0] ev, input string tag);
    step(ev, 0, 0, 8'h00, tag);
    step('0, 1, 0, 8'h00, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mFlags = 4'b1000; mSm = 0; mRd = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check8("R1 reset rdData", rdData, 8'h00);
    check8("R1 reset sm", {7'b0, stopWdtOff}, 8'h00);
    @(negedge clk); rst_n = 1;

    step('0, 1, 0, 8'h00, "R1 first read");          // 0x80
    step('0, 1, 0, 8'h00, "R7 read cleared");        // 0x00
    step('0, 0, 0, 8'h00, "R12 hold");
    evRead(E_EXT, "R3 external");                    // 0x10
    step('0, 0, 1, 8'hFF, "R10 write sm");
    step('0, 1, 0, 8'h00, "R9 reserved zero");       // 0x01
    evRead(E_WRN, "R4 watchdog run");                // 0x21
    evRead(E_DRS, "R5 debugger reset");              // 0x81
    evRead(E_DWK, "R5 debug wake");                  // 0x81
    evRead(E_GPI, "R6 gpio wake");                   // 0x41
    evRead(E_WWK, "R6 watchdog wake");               // 0x61
    evRead(E_POW, "R2 power-on");                    // 0x80
    step(E_EXT, 0, 0, 8'h00, "R8 setup");
    step(E_WRN, 1, 0, 8'h00, "R8 read with event");  // old 0x10
    step('0, 1, 0, 8'h00, "R8 event kept");          // 0x20
    step(E_POW, 0, 1, 8'h01, "R10 power-on beats write");
    evRead(E_EXT | E_WRN, "R11 ext over wdt");
    evRead(E_POW | E_GPI, "R11 power over gpio");
    evRead(E_DWK | E_EXT, "R11 debug wake over ext");
    evRead(E_WWK | E_GPI, "R11 wdt wake over gpio");

    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      logic [6:0] ev;
      logic rd, wr;
      logic [7:0] wd;
      ev = '0;
      for (int b = 0; b < 7; b++) if (($urandom % 8) == 0) ev[b] = 1'b1;
      rd = (($urandom % 3) == 0);
      wr = (($urandom % 5) == 0);
      wd = 8'($urandom);
      step(ev, rd, wr, wd, "R11 random mix");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule